// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns data words into asynchronous serial frames on a single TX line. A frame is made of an optional start field, 5 to 9 data bits sent least significant bit first, an optional parity field and an optional stop field. The stop field may last half a bit, one bit, one and a half bits or two bits. The ninth data bit comes either from the word or from a fixed configuration input. The whole line can be inverted.

Bit timing comes from an oversample tick that pulses 16 times per bit period. The block takes a word from its data interface only when it is idle and enabled, when no inhibit is raised and when the clear-to-send condition allows it. It reports a busy level while a frame is on the line. At the end of a frame it raises a one-cycle complete pulse under a selectable threshold and a one-cycle underrun pulse when no further word is waiting.

Top module: `cfg_serial_tx`

## Requirements
- R1: After reset, and in every cycle in which `busy` is low, `tx_line` sits at the idle level (1, or 0 when `invert_en` is 1); `tx_done`, `tx_underrun` and `data_take` are low after reset.
- R2: With `start_en`=1 a frame begins with one bit period at level 0; with `start_en`=0 the first data bit is on the line from the launch edge.
- R3: Data bits are sent least significant first, each for 16 `tick16` pulses; `len_code` 0, 1, 2 and 3 send 5, 6, 7 and 8 bits, and codes 6 and 7 send 8 bits.
- R4: `len_code` 4 sends 9 bits with the ninth taken from `data_in[8]`; `len_code` 5 sends 9 bits with the ninth taken from `fixed_bit9`.
- R5: With `parity_en`=1 one parity bit follows the data: `parity_mode` 0 makes the count of ones in data plus parity odd, 1 makes it even, 2 sends 1, 3 sends 0. The parity covers only the data bits that are sent.
- R6: With `stop_en`=1 the frame ends with level 1 for 0.5, 1, 1.5 or 2 bit periods for `stop_mode` 0, 1, 2 or 3; with `stop_en`=0 no stop field is sent.
- R7: With `invert_en`=1 every level on `tx_line` is the complement of the non-inverted frame.
- R8: With `cts_gate_en`=1 a new frame starts only while `cts_in` XOR `cts_invert` is 0; a frame already running is not affected.
- R9: Raising `tx_inhibit` lets the running frame finish, including its complete pulse, and no new frame starts while it stays high.
- R10: Dropping `tx_en` ends a running frame at the next clock edge: `busy` goes low, the line returns to idle and no complete pulse is raised.
- R11: `tx_done` pulses for one cycle, in the cycle in which `busy` has just fallen at the end of a frame: after every frame when `cmpl_thresh`=0, and only when `data_valid` is low at that edge when `cmpl_thresh`=1.
- R12: `tx_underrun` pulses for one cycle at the end of a frame when `data_valid` is low at that edge.
- R13: `data_take` is high for one cycle when a word is accepted; `busy` rises at that edge and stays high until the end of the last field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Oversample tick, 16 per bit period |
| tx_en | input | 1 | Transmitter enable; low aborts a frame |
| tx_inhibit | input | 1 | Stall after the running frame |
| start_en | input | 1 | Send a start field |
| parity_en | input | 1 | Send a parity field |
| parity_mode | input | 2 | 0 odd, 1 even, 2 one, 3 zero |
| stop_en | input | 1 | Send a stop field |
| stop_mode | input | 2 | Stop length 0.5/1/1.5/2 bits for 0..3 |
| len_code | input | 3 | Data length selection |
| fixed_bit9 | input | 1 | Ninth bit value for length code 5 |
| invert_en | input | 1 | Invert the TX line |
| cts_gate_en | input | 1 | Gate frame start on clear-to-send |
| cts_invert | input | 1 | Invert the clear-to-send input |
| cts_in | input | 1 | Clear-to-send input |
| cmpl_thresh | input | 1 | Complete pulse only when no word waits |
| data_in | input | 9 | Word to send |
| data_valid | input | 1 | A word is waiting |
| data_take | output | 1 | Word accepted this cycle |
| tx_line | output | 1 | Serial output |
| busy | output | 1 | Frame in progress |
| tx_done | output | 1 | Frame complete pulse |
| tx_underrun | output | 1 | Frame ended with no word waiting |

## Verification
The end of a frame and the arrival of the next word can fall on the same clock edge: the complete decision, the underrun decision and the acceptance of the waiting word all hang on that edge. The bench provokes it by holding `data_valid` high with a second word throughout a frame, under both threshold settings, and judges the number of complete and underrun pulses over the two frames. A second overlap, inhibit raised while a word waits in mid-frame, is judged by the running frame finishing with its pulse and no launch following until the inhibit drops.

// File: rtl/sertx_pkg.sv
// Shared types and helpers for the configurable serial transmitter.
// Assumes the frame word is at most 9 bits wide.
package sertx_pkg;

    localparam int WORD_W = 9;
    localparam int NB_W   = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    // Number of data bits sent for a length code.
    function automatic logic [NB_W-1:0] frame_bits(input logic [2:0] code);
        case (code)
            3'd0:    frame_bits = 4'd5;
            3'd1:    frame_bits = 4'd6;
            3'd2:    frame_bits = 4'd7;
            3'd4,
            3'd5:    frame_bits = 4'd9;
            default: frame_bits = 4'd8;
        endcase
    endfunction

    // Parity bit value over the low n bits of a word.
    function automatic logic parity_value(input logic [1:0] mode,
                                          input logic [WORD_W-1:0] w,
                                          input logic [NB_W-1:0] n);
        logic [WORD_W-1:0] mask;
        logic ones;
        mask = (WORD_W'(1) << n) - WORD_W'(1);
        ones = ^(w & mask);
        case (mode)
            2'd0:    parity_value = ~ones;
            2'd1:    parity_value = ones;
            2'd2:    parity_value = 1'b1;
            default: parity_value = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sertx_bit_timer.sv
// Bit timer: counts oversample ticks within a bit and flags half-bit and
// full-bit boundaries. Assumes OVS is even; restart realigns to a new frame.
module sertx_bit_timer #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    output logic half_done,
    output logic bit_done
);
    localparam int CW   = $clog2(OVS);
    localparam int HALF = OVS / 2;

    logic [CW-1:0] sub;

    // Oversample position inside the current bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sub <= '0;
        else if (restart)
            sub <= '0;
        else if (tick)
            sub <= (sub == CW'(OVS-1)) ? '0 : sub + CW'(1);
    end

    assign bit_done  = tick && (sub == CW'(OVS-1));
    assign half_done = tick && ((sub == CW'(HALF-1)) || (sub == CW'(OVS-1)));

endmodule

// File: rtl/sertx_frame_fsm.sv
// Frame sequencer: walks start, data, parity and stop fields, holds the
// shift register and the per-frame settings latched at launch, and raises
// the end-of-frame pulses. Assumes launch is only asserted while idle.
module sertx_frame_fsm
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              launch,
    input  logic [WORD_W-1:0] word,
    input  logic [NB_W-1:0]   nbits,
    input  logic              start_en,
    input  logic              par_en,
    input  logic              par_bit,
    input  logic              stop_en,
    input  logic [2:0]        stop_halves,
    input  logic              half_done,
    input  logic              bit_done,
    input  logic              pending,
    input  logic              cmpl_thresh,
    output logic              idle,
    output logic              line_raw,
    output logic              done_p,
    output logic              under_p
);
    tx_state_e         state;
    logic [WORD_W-1:0] shreg;
    logic [NB_W-1:0]   cnt;
    logic [2:0]        halves;
    logic              par_q, par_en_q, stop_en_q;
    logic              frame_end;

    // Last field of the frame expires in this cycle.
    always_comb begin
        frame_end = 1'b0;
        case (state)
            ST_DATA: frame_end = bit_done && (cnt == NB_W'(1)) && !par_en_q && !stop_en_q;
            ST_PAR:  frame_end = bit_done && !stop_en_q;
            ST_STOP: frame_end = half_done && (halves == 3'd1);
            default: frame_end = 1'b0;
        endcase
    end

    // Field sequencing, shifting and end-of-frame pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            shreg     <= '0;
            cnt       <= '0;
            halves    <= '0;
            par_q     <= 1'b0;
            par_en_q  <= 1'b0;
            stop_en_q <= 1'b0;
            done_p    <= 1'b0;
            under_p   <= 1'b0;
        end else begin
            done_p  <= 1'b0;
            under_p <= 1'b0;
            if (!tx_en) begin
                state <= ST_IDLE;
            end else if (frame_end) begin
                state   <= ST_IDLE;
                under_p <= !pending;
                done_p  <= !cmpl_thresh || !pending;
            end else begin
                case (state)
                    ST_IDLE: if (launch) begin
                        shreg     <= word;
                        cnt       <= nbits;
                        halves    <= stop_halves;
                        par_q     <= par_bit;
                        par_en_q  <= par_en;
                        stop_en_q <= stop_en;
                        state     <= start_en ? ST_START : ST_DATA;
                    end
                    ST_START: if (bit_done) state <= ST_DATA;
                    ST_DATA: if (bit_done) begin
                        shreg <= shreg >> 1;
                        cnt   <= cnt - NB_W'(1);
                        if (cnt == NB_W'(1))
                            state <= par_en_q ? ST_PAR : ST_STOP;
                    end
                    ST_PAR:  if (bit_done) state <= ST_STOP;
                    ST_STOP: if (half_done) halves <= halves - 3'd1;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Un-inverted line level for the current field.
    always_comb begin
        case (state)
            ST_START: line_raw = 1'b0;
            ST_DATA:  line_raw = shreg[0];
            ST_PAR:   line_raw = par_q;
            default:  line_raw = 1'b1;
        endcase
    end

    assign idle = (state == ST_IDLE);

endmodule

// File: rtl/cfg_serial_tx.sv
// Configurable asynchronous serial transmitter top. Decides when a word may
// be launched (enable, inhibit, clear-to-send), assembles the word and its
// parity, and applies the optional output inversion. Assumes tick16 pulses
// OVS times per bit and data_in is stable while data_valid is high.
module cfg_serial_tx
    import sertx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              tx_en,
    input  logic              tx_inhibit,
    input  logic              start_en,
    input  logic              parity_en,
    input  logic [1:0]        parity_mode,
    input  logic              stop_en,
    input  logic [1:0]        stop_mode,
    input  logic [2:0]        len_code,
    input  logic              fixed_bit9,
    input  logic              invert_en,
    input  logic              cts_gate_en,
    input  logic              cts_invert,
    input  logic              cts_in,
    input  logic              cmpl_thresh,
    input  logic [WORD_W-1:0] data_in,
    input  logic              data_valid,
    output logic              data_take,
    output logic              tx_line,
    output logic              busy,
    output logic              tx_done,
    output logic              tx_underrun
);
    logic              idle, line_raw, half_done, bit_done, cts_ok, launch;
    logic [NB_W-1:0]   nbits;
    logic [WORD_W-1:0] word;
    logic              ninth;

    // Launch permission and word assembly.
    always_comb begin
        cts_ok = !cts_gate_en || !(cts_in ^ cts_invert);
        launch = idle && tx_en && !tx_inhibit && data_valid && cts_ok;
        nbits  = frame_bits(len_code);
        ninth  = (len_code == 3'd5) ? fixed_bit9 : data_in[WORD_W-1];
        word   = {ninth, data_in[WORD_W-2:0]};
    end

    sertx_bit_timer #(.OVS(OVS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (launch),
        .tick      (tick16),
        .half_done (half_done),
        .bit_done  (bit_done)
    );

    sertx_frame_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .launch      (launch),
        .word        (word),
        .nbits       (nbits),
        .start_en    (start_en),
        .par_en      (parity_en),
        .par_bit     (parity_value(parity_mode, word, nbits)),
        .stop_en     (stop_en),
        .stop_halves ({1'b0, stop_mode} + 3'd1),
        .half_done   (half_done),
        .bit_done    (bit_done),
        .pending     (data_valid),
        .cmpl_thresh (cmpl_thresh),
        .idle        (idle),
        .line_raw    (line_raw),
        .done_p      (tx_done),
        .under_p     (tx_underrun)
    );

    assign data_take = launch;
    assign busy      = !idle;
    assign tx_line   = line_raw ^ invert_en;

endmodule

// File: rtl/sertx_checker.sv
// Property checker for cfg_serial_tx, attached with bind below.
module sertx_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic tx_inhibit,
    input logic invert_en,
    input logic cts_gate_en,
    input logic cts_invert,
    input logic cts_in,
    input logic data_take,
    input logic tx_line,
    input logic busy,
    input logic tx_done,
    input logic tx_underrun
);
    // R1: idle line sits at the idle level
    assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tx_line == !invert_en));

    // R8: blocked clear-to-send keeps an idle transmitter idle
    assert_cts_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cts_gate_en && (cts_in ^ cts_invert)) |=> !busy);

    // R9: inhibit keeps an idle transmitter idle
    assert_inhibit_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && tx_inhibit) |=> !busy);

    // R10: dropping the enable ends the frame at once
    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !busy);

    // R11: complete pulse only as busy falls
    assert_done_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> ($past(busy) && !busy));

    // R12: an underrun always comes with the end of a frame
    assert_underrun_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun |-> ($past(busy) && !busy));

    // R13: an accepted word starts a frame
    assert_take_starts_R13: assert property (@(posedge clk) disable iff (!rst_n)
        data_take |=> busy);

endmodule

bind cfg_serial_tx sertx_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en       (tx_en),
    .tx_inhibit  (tx_inhibit),
    .invert_en   (invert_en),
    .cts_gate_en (cts_gate_en),
    .cts_invert  (cts_invert),
    .cts_in      (cts_in),
    .data_take   (data_take),
    .tx_line     (tx_line),
    .busy        (busy),
    .tx_done     (tx_done),
    .tx_underrun (tx_underrun)
);

// File: tb/cfg_serial_tx_tb.sv
module cfg_serial_tx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       tx_en = 1'b0, tx_inhibit = 1'b0;
    logic       start_en = 1'b1, parity_en = 1'b0, stop_en = 1'b1;
    logic [1:0] parity_mode = 2'd0, stop_mode = 2'd1;
    logic [2:0] len_code = 3'd3;
    logic       fixed_bit9 = 1'b0, invert_en = 1'b0;
    logic       cts_gate_en = 1'b0, cts_invert = 1'b0, cts_in = 1'b0;
    logic       cmpl_thresh = 1'b0;
    logic [8:0] data_in = 9'h0;
    logic       data_valid = 1'b0;
    logic       data_take, tx_line, busy, tx_done, tx_underrun;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int n_done = 0, n_under = 0;
    logic exp_lv [0:31];
    int   exp_h;

    always #4 clk = ~clk;   // 125 MHz

    cfg_serial_tx u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .tx_en(tx_en),
        .tx_inhibit(tx_inhibit), .start_en(start_en), .parity_en(parity_en),
        .parity_mode(parity_mode), .stop_en(stop_en), .stop_mode(stop_mode),
        .len_code(len_code), .fixed_bit9(fixed_bit9), .invert_en(invert_en),
        .cts_gate_en(cts_gate_en), .cts_invert(cts_invert), .cts_in(cts_in),
        .cmpl_thresh(cmpl_thresh), .data_in(data_in), .data_valid(data_valid),
        .data_take(data_take), .tx_line(tx_line), .busy(busy),
        .tx_done(tx_done), .tx_underrun(tx_underrun)
    );

    // Oversample tick on every second cycle: one bit is 32 clocks.
    always @(negedge clk) tick16 <= ~tick16;

    // Pulse counters sampled away from the active edge.
    always @(negedge clk) begin
        if (tx_done)     n_done++;
        if (tx_underrun) n_under++;
    end

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_fail++;
            $display("FAIL watchdog: got cycle %0d exp below 190000", cyc);
            summary();
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d exp %0d", tag, got, exp);
        end
    endtask

    function automatic int nb(input logic [2:0] c);
        case (c)
            3'd0: return 5; 3'd1: return 6; 3'd2: return 7;
            3'd4, 3'd5: return 9;
            default: return 8;
        endcase
    endfunction

    // Expected line levels per half bit, computed from the requirements.
    task automatic build(input logic [8:0] w);
        int n = nb(len_code);
        logic [8:0] s = w;
        int ones = 0;
        logic p;
        if (len_code == 3'd5) s[8] = fixed_bit9;
        exp_h = 0;
        if (start_en) begin exp_lv[exp_h++] = 1'b0; exp_lv[exp_h++] = 1'b0; end
        for (int i = 0; i < n; i++) begin
            exp_lv[exp_h++] = s[i]; exp_lv[exp_h++] = s[i];
            ones += int'(s[i]);
        end
        if (parity_en) begin
            case (parity_mode)
                2'd0: p = (ones % 2 == 0);
                2'd1: p = (ones % 2 == 1);
                2'd2: p = 1'b1;
                default: p = 1'b0;
            endcase
            exp_lv[exp_h++] = p; exp_lv[exp_h++] = p;
        end
        if (stop_en)
            for (int i = 0; i <= int'(stop_mode); i++) exp_lv[exp_h++] = 1'b1;
        for (int i = 0; i < exp_h; i++) exp_lv[i] = exp_lv[i] ^ invert_en;
    endtask

    // Send one word and compare every half bit and the end of the frame.
    task automatic frame(input logic [8:0] w, input string tag);
        int c = 0, d0, u0;
        build(w);
        data_in = w; data_valid = 1'b1;
        @(negedge clk);
        data_valid = 1'b0;
        d0 = n_done; u0 = n_under;
        chk({"R13 busy at launch ", tag}, int'(busy), 1);
        for (int k = 0; k < exp_h; k++) begin
            while (c < 16*k + 8) begin @(negedge clk); c++; end
            chk({"R3 half level ", tag}, int'(tx_line), int'(exp_lv[k]));
            chk({"R13 busy in frame ", tag}, int'(busy), 1);
        end
        while (c < 16*exp_h + 4) begin @(negedge clk); c++; end
        chk({"R13 busy after frame ", tag}, int'(busy), 0);
        chk({"R1 idle level ", tag}, int'(tx_line), int'(!invert_en));
        chk({"R11 done count ", tag}, n_done - d0, 1);
        chk({"R12 underrun count ", tag}, n_under - u0, 1);
    endtask

    task automatic wait_busy(input logic v);
        int g = 0;
        while (busy != v && g < 2000) begin @(negedge clk); g++; end
    endtask

    initial begin
        int d0, u0;
        void'($urandom(32'h1A2B3C));
        repeat (5) @(negedge clk);
        // R1: reset state
        chk("R1 reset line", int'(tx_line), 1);
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset done", int'(tx_done), 0);
        chk("R1 reset underrun", int'(tx_underrun), 0);
        chk("R1 reset take", int'(data_take), 0);
        rst_n = 1'b1; tx_en = 1'b1;
        @(negedge clk);

        // R3 lengths, R2 start, R5 parity modes, R6 stop modes
        for (int m = 0; m < 4; m++) begin
            len_code = 3'(m); parity_en = 1'b1; parity_mode = 2'(m);
            stop_mode = 2'(m);
            frame(9'h0A5 + 9'(m * 37), "R2 R5 R6 directed");
            repeat (3) @(negedge clk);
        end
        // R4: ninth bit from word, then from fixed input
        len_code = 3'd4; parity_mode = 2'd1;
        frame(9'h155, "R4 ninth from word");
        len_code = 3'd5; fixed_bit9 = 1'b1;
        frame(9'h055, "R4 ninth fixed");
        // R2 R6: no start, no parity, no stop; then R7 inverted
        start_en = 1'b0; parity_en = 1'b0; stop_en = 1'b0; len_code = 3'd7;
        frame(9'h0C3, "R2 R6 bare data");
        start_en = 1'b1; stop_en = 1'b1; invert_en = 1'b1;
        frame(9'h03C, "R7 inverted");
        invert_en = 1'b0;

        // Random formats
        for (int r = 0; r < 24; r++) begin
            start_en = 1'($urandom); parity_en = 1'($urandom);
            stop_en = 1'($urandom); stop_mode = 2'($urandom);
            parity_mode = 2'($urandom); len_code = 3'($urandom);
            fixed_bit9 = 1'($urandom); invert_en = 1'($urandom);
            cmpl_thresh = 1'($urandom);
            repeat (2) @(negedge clk);
            frame(9'($urandom), "R3 R5 R7 random");
        end
        invert_en = 1'b0; start_en = 1'b1; stop_en = 1'b1; stop_mode = 2'd1;
        parity_en = 1'b0; len_code = 3'd3; cmpl_thresh = 1'b0;
        repeat (4) @(negedge clk);

        // R8: clear-to-send gating
        cts_gate_en = 1'b1; cts_in = 1'b1;
        data_in = 9'h011; data_valid = 1'b1;
        repeat (50) @(negedge clk);
        chk("R8 blocked by cts", int'(busy), 0);
        cts_invert = 1'b1; cts_in = 1'b0;
        repeat (10) @(negedge clk);
        chk("R8 blocked by inverted cts", int'(busy), 0);
        cts_in = 1'b1;
        @(negedge clk);
        data_valid = 1'b0;
        chk("R8 starts when clear", int'(busy), 1);
        cts_in = 1'b0;
        repeat (20) @(negedge clk);
        chk("R8 running frame unaffected", int'(busy), 1);
        wait_busy(1'b0);
        cts_gate_en = 1'b0; cts_invert = 1'b0;
        repeat (4) @(negedge clk);

        // R11 R12: frame end meets a waiting word, threshold 1 then 0
        for (int t = 1; t >= 0; t--) begin
            cmpl_thresh = 1'(t);
            d0 = n_done; u0 = n_under;
            data_in = 9'h0F0; data_valid = 1'b1;
            @(negedge clk);
            data_in = 9'h00F;
            wait_busy(1'b0);
            wait_busy(1'b1);
            data_valid = 1'b0;
            wait_busy(1'b0);
            repeat (4) @(negedge clk);
            chk("R11 done with pending word", n_done - d0, (t == 1) ? 1 : 2);
            chk("R12 underrun with pending word", n_under - u0, 1);
        end
        cmpl_thresh = 1'b0;

        // R9: inhibit mid-frame with a word waiting
        d0 = n_done;
        data_in = 9'h0AA; data_valid = 1'b1;
        @(negedge clk);
        data_in = 9'h055;
        repeat (20) @(negedge clk);
        tx_inhibit = 1'b1;
        repeat (20) @(negedge clk);
        chk("R9 frame continues", int'(busy), 1);
        wait_busy(1'b0);
        repeat (100) @(negedge clk);
        chk("R9 stalled after frame", int'(busy), 0);
        chk("R9 complete pulse kept", n_done - d0, 1);
        tx_inhibit = 1'b0;
        @(negedge clk);
        data_valid = 1'b0;
        chk("R9 resumes on release", int'(busy), 1);
        wait_busy(1'b0);
        repeat (4) @(negedge clk);

        // R10: abort
        d0 = n_done;
        data_in = 9'h0FF; data_valid = 1'b1;
        @(negedge clk);
        data_valid = 1'b0;
        repeat (40) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk("R10 busy after abort", int'(busy), 0);
        chk("R10 idle line after abort", int'(tx_line), 1);
        repeat (20) @(negedge clk);
        chk("R10 no complete on abort", n_done - d0, 0);
        tx_en = 1'b1;
        frame(9'h066, "R10 after abort");

        summary();
    end

endmodule